// File: doc/BRIEF.md
# Dual Data Pointer Controller

This block holds two 16-bit data pointers for an 8-bit processor core together with a small auxiliary control register. One bit of the register picks which pointer appears on the pointer port. Every load, byte write, increment and read made through that port reaches only the chosen pointer. The other pointer keeps its value until software selects it again.

The register is laid out so that software can switch pointers with a plain increment of the whole register. Bits 1 and 2 are wired to zero, so the carry out of the select bit never reaches the general-purpose bits. A separate bit in the register asks for a full processor reset. Writing it raises a one-cycle request toward the reset controller, and at the same edge the block returns to its own reset state. The instruction decoder drives the write, increment and pointer-operation inputs. The reset controller consumes the request. Neither is part of this block.

Top module: `dual_dptr_ctl`

## Requirements
- R1: A register write without bit 3 set stores bits 7:4 and bit 0 of the write data, and `aux_rd_data` shows them from the next cycle.
- R2: Bits 1 and 2 of `aux_rd_data` always read 0. Writing 1 to either bit changes no readable value.
- R3: A register increment without a write toggles bit 0 and leaves bits 7:1 unchanged. Two increments restore the original value.
- R4: When a write and an increment arrive in the same cycle, the write wins and the increment is discarded.
- R5: A write with bit 3 set raises `srst_req` for exactly the next cycle. Bit 3 always reads 0.
- R6: At the edge of a write with bit 3 set, the register returns to 0x00 and both pointers return to 0x0000. The rest of that write's data is discarded, and any pointer operation in that cycle is discarded too.
- R7: After reset the register reads 0x00, both pointers hold 0x0000 and `srst_req` is 0.
- R8: `ptr_rd_data` shows pointer 0 when register bit 0 is 0, and pointer 1 when it is 1.
- R9: `ptr_op` code 1 loads all 16 bits from `ptr_wdata`. Code 3 replaces the low byte with `ptr_wdata[7:0]`. Code 4 replaces the high byte with `ptr_wdata[7:0]`.
- R10: `ptr_op` code 2 adds one to the selected pointer modulo 2^16, so 0xFFFF wraps to 0x0000.
- R11: A pointer operation acts only on the pointer chosen by bit 0 as it stood before the edge, even when the register changes at that same edge. Codes 0, 5, 6 and 7 change neither pointer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| aux_wr_en | input | 1 | Write the auxiliary register |
| aux_wr_data | input | 8 | Data for a register write |
| aux_inc_en | input | 1 | Increment the auxiliary register |
| aux_rd_data | output | 8 | Current register value |
| ptr_op | input | 3 | Pointer operation code |
| ptr_wdata | input | 16 | Data for pointer load and byte writes |
| ptr_rd_data | output | 16 | Value of the selected pointer |
| srst_req | output | 1 | One-cycle full-reset request |

## Verification
The hardest case to reach from the ports is a cycle where a register increment flips the select bit while a pointer operation is also issued. The operation must land on the pointer that was selected before the edge, and the result then sits behind the newly selected pointer. The bench runs every operation code under both select values, with and without a simultaneous increment. Each time, it flips the select back to read both pointers. It also preloads both pointers with non-zero values before a reset-request write, so that the clearing of the hidden pointer can be seen.

// File: rtl/dptr_pkg.sv
package dptr_pkg;

    localparam int AUX_W    = 8;
    localparam int PTR_W    = 16;
    localparam int BYTE_W   = 8;
    localparam int NUM_PTR  = 2;
    localparam int SEL_W    = $clog2(NUM_PTR);

    // Bit positions inside the auxiliary register; the select bit must be
    // bit 0 so that an increment toggles it.
    localparam int SEL_BIT  = 0;
    localparam int PAD_BIT  = 1;
    localparam int ZERO_BIT = 2;
    localparam int SRST_BIT = 3;

    localparam logic [AUX_W-1:0] AUX_ONE  = {{(AUX_W-1){1'b0}}, 1'b1};
    localparam logic [AUX_W-1:0] AUX_RST  = '0;
    localparam logic [AUX_W-1:0] AUX_KEEP =
        ~((AUX_ONE << PAD_BIT) | (AUX_ONE << ZERO_BIT) | (AUX_ONE << SRST_BIT));

    typedef enum logic [2:0] {
        PTR_NOP  = 3'd0,
        PTR_LOAD = 3'd1,
        PTR_INC  = 3'd2,
        PTR_WLO  = 3'd3,
        PTR_WHI  = 3'd4
    } ptr_op_e;

    typedef struct packed {
        logic             wr;
        logic             inc;
        logic [AUX_W-1:0] data;
    } aux_cmd_t;

    typedef struct packed {
        ptr_op_e          op;
        logic [PTR_W-1:0] data;
    } ptr_cmd_t;

    // Apply the hardwired-zero and self-clearing positions to a candidate value.
    function automatic logic [AUX_W-1:0] aux_store(input logic [AUX_W-1:0] v);
        return v & AUX_KEEP;
    endfunction

    function automatic ptr_op_e decode_op(input logic [2:0] code);
        ptr_op_e r;
        case (code)
            3'd1:    r = PTR_LOAD;
            3'd2:    r = PTR_INC;
            3'd3:    r = PTR_WLO;
            3'd4:    r = PTR_WHI;
            default: r = PTR_NOP;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/aux_ctl_reg.sv
module aux_ctl_reg
    import dptr_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  aux_cmd_t         cmd,
    output logic [AUX_W-1:0] aux_q,
    output logic [SEL_W-1:0] sel_q,
    output logic             srst_q,
    output logic             clr_o
);

    logic [AUX_W-1:0] aux_r;
    logic [AUX_W-1:0] aux_nx;
    logic             srst_r;
    logic             srst_hit;

    assign srst_hit = cmd.wr && cmd.data[SRST_BIT];

    // Priority: reset request write, then plain write, then increment.
    always_comb begin
        aux_nx = aux_r;
        if (srst_hit) begin
            aux_nx = AUX_RST;
        end else if (cmd.wr) begin
            aux_nx = aux_store(cmd.data);
        end else if (cmd.inc) begin
            aux_nx = aux_store(aux_r + AUX_ONE);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            aux_r  <= AUX_RST;
            srst_r <= 1'b0;
        end else begin
            aux_r  <= aux_nx;
            srst_r <= srst_hit;
        end
    end

    assign aux_q  = aux_r;
    assign sel_q  = aux_r[SEL_BIT +: SEL_W];
    assign srst_q = srst_r;
    assign clr_o  = srst_hit;

    // R1 / R4: a plain write lands even when an increment arrives with it
    p_write_r1: assert property (@(posedge clk) disable iff (rst)
        (cmd.wr && !cmd.data[SRST_BIT]) |=> (aux_q == ($past(cmd.data) & 8'hF1)));

    // R3: increment flips only the select bit
    p_inc_toggle_r3: assert property (@(posedge clk) disable iff (rst)
        (cmd.inc && !cmd.wr) |=> (aux_q == ($past(aux_q) ^ AUX_ONE)));

    // R5: every request pulse follows a write of the request bit
    p_srst_cause_r5: assert property (@(posedge clk) disable iff (rst)
        srst_q |-> $past(cmd.wr && cmd.data[SRST_BIT]));

    // R6: while the request is up the register holds its reset value
    p_srst_clear_r6: assert property (@(posedge clk) disable iff (rst)
        srst_q |-> (aux_q == AUX_RST));

endmodule

// File: rtl/ptr_slot.sv
module ptr_slot
    import dptr_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             clr,
    input  logic             en,
    input  ptr_cmd_t         cmd,
    output logic [PTR_W-1:0] q
);

    logic [PTR_W-1:0] q_r;
    logic [PTR_W-1:0] q_nx;

    always_comb begin
        q_nx = q_r;
        if (en) begin
            case (cmd.op)
                PTR_LOAD: q_nx = cmd.data;
                PTR_INC:  q_nx = q_r + {{(PTR_W-1){1'b0}}, 1'b1};
                PTR_WLO:  q_nx[BYTE_W-1:0] = cmd.data[BYTE_W-1:0];
                PTR_WHI:  q_nx[PTR_W-1:BYTE_W] = cmd.data[BYTE_W-1:0];
                default:  q_nx = q_r;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            q_r <= '0;
        end else begin
            q_r <= q_nx;
        end
    end

    assign q = q_r;

    // R10: increment of the selected pointer
    p_ptr_inc_r10: assert property (@(posedge clk) disable iff (rst)
        (en && !clr && cmd.op == PTR_INC) |=> (q == $past(q) + 16'd1));

    // R11: an unselected pointer keeps its value
    p_ptr_hold_r11: assert property (@(posedge clk) disable iff (rst)
        (!en && !clr) |=> $stable(q));

    // R6: reset request clears the pointer
    p_ptr_clr_r6: assert property (@(posedge clk) disable iff (rst)
        clr |=> (q == '0));

endmodule

// File: rtl/dptr_bank.sv
module dptr_bank
    import dptr_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             clr,
    input  logic [SEL_W-1:0] sel,
    input  ptr_cmd_t         cmd,
    output logic [PTR_W-1:0] rd_q
);

    logic [PTR_W-1:0] slot_q [NUM_PTR];

    for (genvar i = 0; i < NUM_PTR; i++) begin : g_slot
        ptr_slot u_slot (
            .clk (clk),
            .rst (rst),
            .clr (clr),
            .en  (sel == SEL_W'(i)),
            .cmd (cmd),
            .q   (slot_q[i])
        );
    end

    assign rd_q = slot_q[sel];

    // R9: a full load shows up on the read port when the select is unchanged
    p_load_r9: assert property (@(posedge clk) disable iff (rst)
        (cmd.op == PTR_LOAD && !clr) ##1 ($past(sel) == sel) |-> (rd_q == $past(cmd.data)));

endmodule

// File: rtl/dual_dptr_ctl.sv
module dual_dptr_ctl
    import dptr_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        aux_wr_en,
    input  logic [7:0]  aux_wr_data,
    input  logic        aux_inc_en,
    output logic [7:0]  aux_rd_data,
    input  logic [2:0]  ptr_op,
    input  logic [15:0] ptr_wdata,
    output logic [15:0] ptr_rd_data,
    output logic        srst_req
);

    aux_cmd_t         aux_cmd;
    ptr_cmd_t         ptr_cmd;
    logic [SEL_W-1:0] sel;
    logic             clr;

    always_comb begin
        aux_cmd.wr   = aux_wr_en;
        aux_cmd.inc  = aux_inc_en;
        aux_cmd.data = aux_wr_data;
        ptr_cmd.op   = decode_op(ptr_op);
        ptr_cmd.data = ptr_wdata;
    end

    aux_ctl_reg u_aux (
        .clk    (clk),
        .rst    (rst),
        .cmd    (aux_cmd),
        .aux_q  (aux_rd_data),
        .sel_q  (sel),
        .srst_q (srst_req),
        .clr_o  (clr)
    );

    dptr_bank u_bank (
        .clk  (clk),
        .rst  (rst),
        .clr  (clr),
        .sel  (sel),
        .cmd  (ptr_cmd),
        .rd_q (ptr_rd_data)
    );

    // R2: the hardwired bits never read back as 1
    p_zero_bits_r2: assert property (@(posedge clk) disable iff (rst)
        $past(aux_wr_en) |-> (aux_rd_data[2:1] == 2'b00));

    // R5: the request never lasts two cycles without a second request write
    p_srst_pulse_r5: assert property (@(posedge clk) disable iff (rst)
        (srst_req && !(aux_wr_en && aux_wr_data[3])) |=> !srst_req);

endmodule

// File: tb/test_dual_dptr_ctl.sv
module test_dual_dptr_ctl;

    logic        clk = 1'b0;
    logic        rst;
    logic        aux_wr_en;
    logic [7:0]  aux_wr_data;
    logic        aux_inc_en;
    logic [7:0]  aux_rd_data;
    logic [2:0]  ptr_op;
    logic [15:0] ptr_wdata;
    logic [15:0] ptr_rd_data;
    logic        srst_req;

    int  n_checks = 0;
    int  n_errors = 0;
    bit  done     = 1'b0;

    logic [7:0]  exp_aux;
    logic [15:0] exp_p0;
    logic [15:0] exp_p1;
    logic        exp_srst;

    always #5 clk = ~clk;

    dual_dptr_ctl i_dual_dptr_ctl (
        .clk         (clk),
        .rst         (rst),
        .aux_wr_en   (aux_wr_en),
        .aux_wr_data (aux_wr_data),
        .aux_inc_en  (aux_inc_en),
        .aux_rd_data (aux_rd_data),
        .ptr_op      (ptr_op),
        .ptr_wdata   (ptr_wdata),
        .ptr_rd_data (ptr_rd_data),
        .srst_req    (srst_req)
    );

    task automatic chk(input string tag, input string what, input logic [15:0] act, input logic [15:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    task automatic compare(input string tag);
        chk(tag, "aux", {8'h00, aux_rd_data}, {8'h00, exp_aux});
        chk(tag, "ptr", ptr_rd_data, exp_aux[0] ? exp_p1 : exp_p0);
        chk(tag, "srst", {15'd0, srst_req}, {15'd0, exp_srst});
    endtask

    function automatic logic [15:0] apply_op(input logic [2:0] op, input logic [15:0] p, input logic [15:0] d);
        case (op)
            3'd1:    return d;
            3'd2:    return p + 16'd1;
            3'd3:    return (p & 16'hFF00) | {8'h00, d[7:0]};
            3'd4:    return (p & 16'h00FF) | {d[7:0], 8'h00};
            default: return p;
        endcase
    endfunction

    // One clock of stimulus: inputs driven after a falling edge, results read
    // at the next falling edge.
    task automatic step(input bit wr, input logic [7:0] wd, input bit inc,
                        input logic [2:0] op, input logic [15:0] pd, input string tag);
        logic sel;
        sel = exp_aux[0];
        aux_wr_en   = wr;
        aux_wr_data = wd;
        aux_inc_en  = inc;
        ptr_op      = op;
        ptr_wdata   = pd;
        if (wr && wd[3]) begin
            exp_srst = 1'b1;
            exp_aux  = 8'h00;
            exp_p0   = 16'h0000;
            exp_p1   = 16'h0000;
        end else begin
            exp_srst = 1'b0;
            if (sel) exp_p1 = apply_op(op, exp_p1, pd);
            else     exp_p0 = apply_op(op, exp_p0, pd);
            if (wr)       exp_aux = wd & 8'hF1;
            else if (inc) exp_aux = exp_aux ^ 8'h01;
        end
        @(negedge clk);
        aux_wr_en  = 1'b0;
        aux_inc_en = 1'b0;
        ptr_op     = 3'd0;
        compare(tag);
    endtask

    task automatic idle(input string tag);
        step(1'b0, 8'h00, 1'b0, 3'd0, 16'h0000, tag);
    endtask

    initial begin
        rst = 1'b1;
        aux_wr_en = 1'b0; aux_wr_data = 8'h00; aux_inc_en = 1'b0;
        ptr_op = 3'd0; ptr_wdata = 16'h0000;
        exp_aux = 8'h00; exp_p0 = 16'h0000; exp_p1 = 16'h0000; exp_srst = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        compare("R7");

        // R1 R2 R5 R6: every write value, including those asking for reset
        for (int v = 0; v < 256; v++) begin
            step(1'b1, 8'(v), 1'b0, 3'd0, 16'h0000, (v & 8) ? "R5_R6" : "R1_R2");
            if (v & 8) idle("R5");
        end

        // R3: increment from every storable value, twice
        for (int v = 0; v < 256; v++) begin
            if ((v & 8) == 0) begin
                step(1'b1, 8'(v), 1'b0, 3'd0, 16'h0000, "R1");
                step(1'b0, 8'h00, 1'b1, 3'd0, 16'h0000, "R3");
                step(1'b0, 8'h00, 1'b1, 3'd0, 16'h0000, "R3");
            end
        end

        // R4: write and increment together
        for (int v = 0; v < 256; v += 17) begin
            step(1'b1, 8'(v & 8'hF7), 1'b1, 3'd0, 16'h0000, "R4");
        end

        // R8 R9 R10 R11: every op code, both selects, with and without a
        // simultaneous register increment; read the other pointer afterwards
        for (int s = 0; s < 2; s++) begin
            for (int op = 0; op < 8; op++) begin
                for (int k = 0; k < 2; k++) begin
                    step(1'b1, 8'h00, 1'b0, 3'd1, 16'h1234, "R9");
                    step(1'b1, 8'h01, 1'b0, 3'd1, 16'hABCD, "R9");
                    step(1'b1, 8'(s), 1'b0, 3'd0, 16'h0000, "R8");
                    step(1'b0, 8'h00, k[0], 3'(op), 16'h5A7E,
                         (op == 2) ? "R10" : ((op == 0 || op > 4) ? "R11" : "R9"));
                    step(1'b0, 8'h00, 1'b1, 3'd0, 16'h0000, "R11");
                    step(1'b0, 8'h00, 1'b1, 3'd0, 16'h0000, "R11");
                end
            end
        end

        // R10: wrap on both pointers
        for (int s = 0; s < 2; s++) begin
            step(1'b1, 8'(s), 1'b0, 3'd0, 16'h0000, "R8");
            step(1'b0, 8'h00, 1'b0, 3'd1, 16'hFFFF, "R9");
            step(1'b0, 8'h00, 1'b0, 3'd2, 16'h0000, "R10");
            step(1'b0, 8'h00, 1'b0, 3'd2, 16'h0000, "R10");
        end

        // R6: reset request with both pointers non-zero and an op in flight
        step(1'b1, 8'hF0, 1'b0, 3'd1, 16'h0F0F, "R9");
        step(1'b1, 8'hF1, 1'b0, 3'd1, 16'hF0F0, "R9");
        step(1'b1, 8'hF9, 1'b0, 3'd1, 16'h7777, "R6");
        idle("R5");
        step(1'b0, 8'h00, 1'b1, 3'd0, 16'h0000, "R6");

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_errors++;
            n_checks++;
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    end

endmodule